// File: doc/BRIEF.md
# Single-Bit Predicate Result Packer

This unit gathers a stream of one-bit reduction results, one per vector element, and packs them into 64-bit integer destination words. A vector run begins with a start pulse that carries the vector length (0 to 64), a 2-bit packing code and a scalar-destination flag. Each result is then offered with a valid/ready handshake, in element order from 0 upwards.

The packing code sets how many results share one destination element. Code `00` gives 1 per element, `01` gives 2, `10` gives 4 and `11` gives 8, so k equals 2 raised to the code value. Result i lands in destination element i/k, at arithmetic bit (i mod k), where bit 0 is the LSB. In scalar-destination mode the code is ignored and every result goes into a single register, with result i at bit i. Each finished word leaves the unit as a one-cycle strobe together with its destination element index. Words are always zero-filled. A done pulse marks the end of the run.

Top module: `pred_bit_packer`

## Requirements
- R1: After reset, `out_valid`, `done` and `in_ready` are all low.
- R2: With packing code 00 and scalar mode off, destination element i holds result i in bit 0.
- R3: With packing codes 01, 10 and 11 (k = 2, 4, 8), result i is placed at bit (i mod k) of destination element i/k. `out_idx` carries i/k.
- R4: Every bit of an emitted word that holds no result is zero. This covers the bits at and above k, and the unused slots of a partly filled final word.
- R5: In scalar mode, result i goes to bit i of one word, emitted with `out_idx` 0. Only one word is emitted per run.
- R6: A word is strobed on `out_valid` for exactly one cycle, starting in the cycle after the clock edge that accepts its k-th result. A partly filled word is strobed the same way after the last result of the vector.
- R7: While `out_valid` is high, `in_ready` is low. A result offered during that cycle is not taken until `in_ready` returns.
- R8: `done` pulses for one cycle, coinciding with the strobe of the final word. A start with vector length 0 gives a `done` pulse in the next cycle and no word.
- R9: A start pulse in the middle of a run discards the partial accumulation and the element count. The new run packs from element 0 into a cleared word.
- R10: While no run is active, `in_ready` is low, and `in_valid` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run and latches the configuration |
| cfg_vlen | input | 7 | Vector length, 0 to 64 |
| cfg_code | input | 2 | Packing code: k = 1 shifted left by the code |
| cfg_scalar | input | 1 | Pack every result into one destination word |
| in_valid | input | 1 | A result bit is offered |
| in_bit | input | 1 | Result bit for the current element |
| in_ready | output | 1 | The unit can take a result |
| out_valid | output | 1 | Write strobe for a finished destination word |
| out_idx | output | 6 | Destination element index |
| out_word | output | 64 | Packed destination word |
| done | output | 1 | Run finished |

## Verification
A result is accepted on the rising edge where both `in_valid` and `in_ready` are high. When it closes a word, `out_valid`, `out_idx` and `out_word` show that word in the next cycle. When it is the last element, `done` shows in that same next cycle. The bench drives inputs on falling edges and then samples the outputs on the following falling edge, exactly one register stage after the accepting edge. There it requires the strobe to be present or absent according to whether (i mod k) = k-1 or i is the last element. When the strobe is present, it also requires `in_ready` to be low at that point and low again when the next element is offered.

// File: rtl/ppk_pkg.sv
package ppk_pkg;
    typedef enum logic [1:0] {
        PACK_X1 = 2'b00,
        PACK_X2 = 2'b01,
        PACK_X4 = 2'b10,
        PACK_X8 = 2'b11
    } pack_code_e;
endpackage

// File: rtl/ppk_slot_map.sv
// Maps an element index to its destination element and bit position.
module ppk_slot_map
    import ppk_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int POS_W = 6
) (
    input  logic [IDX_W-1:0] elem_idx,
    input  pack_code_e       code,
    input  logic             scalar,
    output logic [POS_W-1:0] bit_pos,
    output logic [IDX_W-1:0] word_idx,
    output logic             slot_last
);
    localparam int LG_W = $clog2(POS_W + 1);

    logic [LG_W-1:0]  log2k;
    logic [POS_W:0]   kfull;
    logic [POS_W-1:0] kmask;
    logic [POS_W-1:0] idx_ext;

    always_comb begin
        log2k    = scalar ? LG_W'(POS_W) : LG_W'(code);
        kfull    = (POS_W+1)'(1) << log2k;
        kmask    = POS_W'(kfull - (POS_W+1)'(1));
        idx_ext  = POS_W'(elem_idx);
        bit_pos  = idx_ext & kmask;
        word_idx = elem_idx >> log2k;
        slot_last = (bit_pos == kmask);
    end
endmodule

// File: rtl/ppk_lane_insert.sv
// Writes one bit into a selected lane of the accumulator word.
module ppk_lane_insert #(
    parameter int WORD_W = 64,
    parameter int POS_W  = 6
) (
    input  logic [WORD_W-1:0] acc_in,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              bit_in,
    output logic [WORD_W-1:0] acc_out
);
    for (genvar j = 0; j < WORD_W; j++) begin : g_lane
        assign acc_out[j] = (bit_pos == POS_W'(j)) ? bit_in : acc_in[j];
    end
endmodule

// File: rtl/pred_bit_packer.sv
module pred_bit_packer
    import ppk_pkg::*;
#(
    parameter int VL_MAX = 64,
    parameter int WORD_W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [$clog2(VL_MAX):0]     cfg_vlen,
    input  logic [1:0]                  cfg_code,
    input  logic                        cfg_scalar,
    input  logic                        in_valid,
    input  logic                        in_bit,
    output logic                        in_ready,
    output logic                        out_valid,
    output logic [$clog2(VL_MAX)-1:0]   out_idx,
    output logic [WORD_W-1:0]           out_word,
    output logic                        done
);
    localparam int IDX_W = $clog2(VL_MAX);
    localparam int POS_W = $clog2(WORD_W);

    typedef struct packed {
        logic              busy;
        logic [IDX_W:0]    cnt;
        logic [IDX_W:0]    vlen;
        pack_code_e        code;
        logic              scalar;
        logic [WORD_W-1:0] acc;
        logic              ov;
        logic [IDX_W-1:0]  oidx;
        logic [WORD_W-1:0] oword;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    logic [POS_W-1:0]  bit_pos;
    logic [IDX_W-1:0]  word_idx;
    logic              slot_last;
    logic [WORD_W-1:0] acc_ins;
    logic              accept;
    logic              elem_last;

    ppk_slot_map #(.IDX_W(IDX_W), .POS_W(POS_W)) i_map (
        .elem_idx (st_q.cnt[IDX_W-1:0]),
        .code     (st_q.code),
        .scalar   (st_q.scalar),
        .bit_pos  (bit_pos),
        .word_idx (word_idx),
        .slot_last(slot_last)
    );

    ppk_lane_insert #(.WORD_W(WORD_W), .POS_W(POS_W)) i_ins (
        .acc_in (st_q.acc),
        .bit_pos(bit_pos),
        .bit_in (in_bit),
        .acc_out(acc_ins)
    );

    assign in_ready  = st_q.busy && !st_q.ov;
    assign accept    = in_valid && in_ready && !start;
    assign elem_last = ((st_q.cnt + (IDX_W+1)'(1)) == st_q.vlen);

    always_comb begin
        st_d      = st_q;
        st_d.ov   = 1'b0;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy   = (cfg_vlen != '0);
            st_d.done   = (cfg_vlen == '0);
            st_d.cnt    = '0;
            st_d.acc    = '0;
            st_d.vlen   = cfg_vlen;
            st_d.code   = pack_code_e'(cfg_code);
            st_d.scalar = cfg_scalar;
        end else if (accept) begin
            st_d.cnt = st_q.cnt + (IDX_W+1)'(1);
            if (slot_last || elem_last) begin
                st_d.ov    = 1'b1;
                st_d.oword = acc_ins;
                st_d.oidx  = word_idx;
                st_d.acc   = '0;
            end else begin
                st_d.acc = acc_ins;
            end
            if (elem_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_idx   = st_q.oidx;
    assign out_word  = st_q.oword;
    assign done      = st_q.done;

    // R7: no result taken while a word is pending
    a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov |-> !in_ready);
    // R6: strobe lasts one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov |=> !st_q.ov);
    // R6: every strobe is caused by an accepted result
    a_r6_word_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov |-> $past(in_valid && in_ready));
    // R8: done is a single-cycle pulse and ends the run
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !in_ready);
    // R5: scalar destination always uses element 0
    a_r5_scalar_idx0: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov && st_q.scalar) |-> (st_q.oidx == '0));
    // R4: nothing above bit k-1 in a packed word
    a_r4_word_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov && !st_q.scalar) |-> ((st_q.oword >> (8'd1 << st_q.code)) == '0));
endmodule

// File: tb/test_pred_bit_packer.sv
module test_pred_bit_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  cfg_vlen = '0;
    logic [1:0]  cfg_code = '0;
    logic        cfg_scalar = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [5:0]  out_idx;
    logic [63:0] out_word;
    logic        done;

    int checks = 0;
    int errors = 0;
    int wd = 0;

    always #10 clk = ~clk;   // 50 MHz

    pred_bit_packer i_pred_bit_packer (
        .clk, .rst_n, .start, .cfg_vlen, .cfg_code, .cfg_scalar,
        .in_valid, .in_bit, .in_ready, .out_valid, .out_idx, .out_word, .done
    );

    typedef struct packed {
        logic [6:0]  vlen;
        logic [1:0]  code;
        logic        scalar;
        logic [63:0] pat;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{7'd5,  2'b00, 1'b0, 64'h15},                 // R2
        '{7'd7,  2'b01, 1'b0, 64'h5B},                 // R3 k=2, partial tail
        '{7'd10, 2'b10, 1'b0, 64'h2D3},                // R3 k=4, partial tail
        '{7'd20, 2'b11, 1'b0, 64'hA5C3F},              // R3 k=8
        '{7'd64, 2'b11, 1'b0, 64'hDEADBEEF0123CAFE},   // R3 full length
        '{7'd64, 2'b01, 1'b0, 64'h0F1E2D3C4B5A6978},   // R3 k=2 full
        '{7'd37, 2'b10, 1'b1, 64'hFFFFFF1F0F0F3C3C},   // R5 partial scalar
        '{7'd64, 2'b00, 1'b1, 64'hFFFF0000AAAA5555},   // R5 full scalar
        '{7'd0,  2'b10, 1'b0, 64'h0}                   // R8 empty run
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input int vlen, input int k, input int w,
                                             input logic [63:0] pat);
        logic [63:0] r = '0;
        for (int j = 0; j < k; j++)
            if (w * k + j < vlen) r[j] = pat[w * k + j];
        return r;
    endfunction

    task automatic do_start(input int vlen, input logic [1:0] code, input logic sc);
        @(negedge clk);
        start = 1'b1; cfg_vlen = 7'(vlen); cfg_code = code; cfg_scalar = sc;
        @(negedge clk);
        start = 1'b0;
    endtask

    // feeds elements lo..hi-1 of a run, checking timing and words
    task automatic feed(input int vlen, input logic [1:0] code, input logic sc,
                        input logic [63:0] pat, input int lo, input int hi);
        int k = sc ? 64 : (1 << code);
        for (int i = lo; i < hi; i++) begin
            in_valid = 1'b1; in_bit = pat[i];
            while (!in_ready) begin
                @(negedge clk);
                wd++;
                if (wd > 1000) begin chk("R7 watchdog", 0, 1); return; end
            end
            wd = 0;
            @(negedge clk);
            in_valid = 1'b0;
            if ((i % k) == k - 1 || i == vlen - 1) begin
                chk("R6 strobe", 64'(out_valid), 64'd1);
                chk(sc ? "R5 index" : "R3 index", 64'(out_idx), 64'(i / k));
                chk(sc ? "R5 word" : (code == 2'b00 ? "R2 word" : "R4 word"),
                    out_word, exp_word(vlen, k, i / k, pat));
                chk("R7 ready low", 64'(in_ready), 64'd0);
            end else begin
                chk("R6 no strobe", 64'(out_valid), 64'd0);
            end
            chk("R8 done", 64'(done), 64'(i == vlen - 1));
        end
    endtask

    initial begin
        // R1 reset state
        #5;
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R10 idle: offered results are ignored
        in_valid = 1'b1; in_bit = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R10 idle ready", 64'(in_ready), 64'd0);
            chk("R10 idle strobe", 64'(out_valid), 64'd0);
        end
        in_valid = 1'b0;

        // vector table
        for (int v = 0; v < NV; v++) begin
            do_start(int'(VECS[v].vlen), VECS[v].code, VECS[v].scalar);
            if (VECS[v].vlen == 0) begin
                chk("R8 empty done", 64'(done), 64'd1);
                chk("R8 empty no word", 64'(out_valid), 64'd0);
            end else begin
                feed(int'(VECS[v].vlen), VECS[v].code, VECS[v].scalar, VECS[v].pat,
                     0, int'(VECS[v].vlen));
            end
            @(negedge clk);
            chk("R8 done single", 64'(done), 64'd0);
            chk("R6 strobe single", 64'(out_valid), 64'd0);
        end

        // R9 restart mid-run: stale ones must not leak into the new word
        do_start(16, 2'b11, 1'b0);
        feed(16, 2'b11, 1'b0, 64'hFFFF, 0, 3);
        do_start(8, 2'b11, 1'b0);
        feed(8, 2'b11, 1'b0, 64'h80, 0, 8);
        @(negedge clk);
        chk("R9 after restart idle", 64'(in_ready), 64'd0);

        // R4 high bits zero after a dense run, then sparse k=4 word
        do_start(3, 2'b10, 1'b0);
        feed(3, 2'b10, 1'b0, 64'h7, 0, 3);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule